// File: doc/BRIEF.md
# Staged Configuration Register Bank

This block holds the configuration bytes of a device in two copies. A serial slave writes bytes through a byte-wide write port. Those bytes land only in a staging copy. A second, live copy drives the device's control logic through one wide output. The live copy changes only when the host commits the staged values. To commit, the host writes a byte to the commit register with its lowest bit set. On the following clock, every staged byte moves to the live copy at once, and the commit bit clears itself.

Reads through the byte read port always return the staged copy, so the host sees what it has written even before a commit. There is one exception to the two-copy rule: the port-mode bit at address 0x00, bit 7. It is taken straight from the staging copy and fed back to the serial slave, so the host can change the wiring mode of the port without a commit. Addresses at or above the implemented count are not backed by storage.

Top module: `dbuf_regbank`

## Requirements
- R1: After reset, staged and live register k both hold ((k*37+5) mod 256) AND 0x7E, and `port_mode_4w` is 0.
- R2: A write with `wr_en` high to an in-range address updates the staged byte at the clock edge. From the next cycle, `rd_data` for that address shows the new value.
- R3: Writes that are not followed by a commit leave `live_regs` unchanged. Live byte k sits at bits [8k+7:8k].
- R4: Writing a byte with bit 0 set to address 0x5A (the commit register) makes every live byte equal its staged byte on the next clock edge. The live copy of bit 0 of 0x5A is 0.
- R5: The commit bit clears itself in the same edge as the transfer. Afterwards a read of 0x5A shows bit 0 as 0, and the other bits of 0x5A keep the written value.
- R6: Any number of staged bytes written before a commit all reach `live_regs` in the same clock edge.
- R7: `rd_data` returns the staged value, which differs from the live value until a commit.
- R8: `port_mode_4w` equals staged bit 7 of address 0x00 in the cycle after that byte is written, with no commit needed.
- R9: A write to an address of 96 or more changes nothing. A read from such an address returns 0x00.
- R10: Writing 0x5A with bit 0 clear causes no transfer.
- R11: A commit write that arrives in the same edge as a transfer re-arms the commit bit, so a second transfer follows on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Staged byte at `rd_addr`, combinational |
| live_regs | output | 768 | Live copy, byte k at bits [8k+7:8k] |
| port_mode_4w | output | 1 | Port-mode bit, staged address 0x00 bit 7 |

## Verification
The hardest case to reach is a commit write that lands in the very edge where a previous commit is being carried out. In that case, the self-clear and the new write compete for the same bit. The random stimulus rarely lines these up, so a directed sequence issues two commit writes back to back. It then checks that the second one survives and causes a second transfer. Every cycle of the random phase is compared against a bench model that applies the pending transfer before the write at each edge. This catches any ordering slip between the two.

// File: rtl/dbuf_regbank.sv
module dbuf_regbank #(
  parameter int NUM_REGS  = 96,
  parameter int UPD_ADDR  = 90,
  parameter int MODE_ADDR = 0,
  parameter int MODE_BIT  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] live_regs,
  output logic                  port_mode_4w
);
  localparam int IW = $clog2(NUM_REGS);

  logic [NUM_REGS*8-1:0] stage_bus;
  logic                  upd_armed;
  logic                  wr_ok;
  logic [IW-1:0]         wr_idx;
  logic [IW-1:0]         rd_idx;

  assign wr_ok     = wr_en && (int'(wr_addr) < NUM_REGS);
  assign wr_idx    = wr_addr[IW-1:0];
  assign rd_idx    = rd_addr[IW-1:0];
  assign upd_armed = stage_bus[UPD_ADDR*8];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] DFLT = 8'((g * 37 + 5) % 256) & 8'h7E;
    logic [7:0] stg_q;
    logic [7:0] live_q;
    logic       hit;

    assign hit = wr_ok && (int'(wr_idx) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q  <= DFLT;
        live_q <= DFLT;
      end else begin
        if (upd_armed) begin
          if (g == UPD_ADDR) begin
            live_q   <= {stg_q[7:1], 1'b0};
            stg_q[0] <= 1'b0;
          end else begin
            live_q <= stg_q;
          end
        end
        if (hit) stg_q <= wr_data;
      end
    end

    assign stage_bus[g*8 +: 8] = stg_q;
    assign live_regs[g*8 +: 8] = live_q;
  end

  assign rd_data      = (int'(rd_addr) < NUM_REGS) ? stage_bus[{rd_idx, 3'b000} +: 8] : 8'h00;
  assign port_mode_4w = stage_bus[MODE_ADDR*8 + MODE_BIT];
endmodule

// File: rtl/dbuf_regbank_chk.sv
module dbuf_regbank_chk #(
  parameter int NUM_REGS  = 96,
  parameter int UPD_ADDR  = 90,
  parameter int MODE_ADDR = 0,
  parameter int MODE_BIT  = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [7:0]            wr_addr,
  input logic [7:0]            wr_data,
  input logic [7:0]            rd_addr,
  input logic [7:0]            rd_data,
  input logic [NUM_REGS*8-1:0] live_regs,
  input logic [NUM_REGS*8-1:0] stage_bus,
  input logic                  port_mode_4w
);
  logic armed;
  logic commit_wr;
  assign armed     = stage_bus[UPD_ADDR*8];
  assign commit_wr = wr_en && (int'(wr_addr) == UPD_ADDR) && wr_data[0];

  // R3
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(live_regs));

  // R4
  arm_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |=> armed);

  // R5
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !commit_wr |=> !armed);

  // R4
  live_commit_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> !live_regs[UPD_ADDR*8]);

  // R8
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (int'(wr_addr) == MODE_ADDR) |=> port_mode_4w == $past(wr_data[MODE_BIT]));

  // R9
  oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) >= NUM_REGS) |-> rd_data == 8'h00);
endmodule

bind dbuf_regbank dbuf_regbank_chk #(
  .NUM_REGS(NUM_REGS), .UPD_ADDR(UPD_ADDR), .MODE_ADDR(MODE_ADDR), .MODE_BIT(MODE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .live_regs(live_regs),
  .stage_bus(stage_bus), .port_mode_4w(port_mode_4w)
);

// File: tb/dbuf_regbank_tb.sv
module dbuf_regbank_tb;
  localparam int NREG = 96;
  localparam int UPD  = 90;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_addr = 8'h00;
  logic [7:0]        wr_data = 8'h00;
  logic [7:0]        rd_addr = 8'h00;
  logic [7:0]        rd_data;
  logic [NREG*8-1:0] live_regs;
  logic              port_mode_4w;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  logic [7:0] mb [NREG];
  logic [7:0] ma [NREG];

  dbuf_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .live_regs(live_regs), .port_mode_4w(port_mode_4w)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] dflt(int k);
    return 8'((k * 37 + 5) % 256) & 8'h7E;
  endfunction

  function automatic logic [NREG*8-1:0] exp_live();
    logic [NREG*8-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*8 +: 8] = ma[k];
    return v;
  endfunction

  task automatic model_edge(input logic we, input logic [7:0] a, input logic [7:0] d);
    if (mb[UPD][0]) begin
      for (int k = 0; k < NREG; k++) ma[k] = mb[k];
      ma[UPD][0] = 1'b0;
      mb[UPD][0] = 1'b0;
    end
    if (we && int'(a) < NREG) mb[a] = d;
  endtask

  task automatic cycle(input logic we, input logic [7:0] a, input logic [7:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_edge(we, a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_live(input string req);
    checks++;
    if (live_regs !== exp_live()) begin
      errors++;
      $display("FAIL %s live_regs got %h exp %h", req, live_regs, exp_live());
    end
  endtask

  task automatic chk_rd(input logic [7:0] a, input string req);
    logic [7:0] e;
    rd_addr = a;
    #0.5;
    e = (int'(a) < NREG) ? mb[a] : 8'h00;
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s rd addr %0h got %h exp %h", req, a, rd_data, e);
    end
  endtask

  task automatic chk_mode(input string req);
    checks++;
    if (port_mode_4w !== mb[0][7]) begin
      errors++;
      $display("FAIL %s port_mode_4w got %b exp %b", req, port_mode_4w, mb[0][7]);
    end
  endtask

  initial begin
    void'($urandom(32'd4421));
    for (int k = 0; k < NREG; k++) begin mb[k] = dflt(k); ma[k] = dflt(k); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < NREG; k++) chk_rd(8'(k), "R1");
    chk_live("R1");
    chk_mode("R1");

    // R8 mode bit immediate, R3 live untouched
    cycle(1'b1, 8'h00, 8'h80);
    chk_mode("R8");
    chk_live("R3");
    cycle(1'b1, 8'h00, 8'h13);
    chk_mode("R8");

    // R2, R7, R3 staged writes
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a;
      a = 8'($urandom_range(1, NREG - 1));
      if (int'(a) == UPD) a = 8'h01;
      cycle(1'b1, a, 8'($urandom));
      chk_rd(a, "R2");
      chk_live("R3");
    end
    chk_rd(8'h05, "R7");

    // R10 commit register without bit 0
    cycle(1'b1, 8'(UPD), 8'h3C);
    cycle(1'b0, 8'h00, 8'h00);
    chk_live("R10");
    chk_rd(8'(UPD), "R10");

    // R4, R5, R6 commit
    cycle(1'b1, 8'(UPD), 8'h41);
    chk_live("R3");
    chk_rd(8'(UPD), "R4");
    cycle(1'b0, 8'h00, 8'h00);
    chk_live("R6");
    chk_rd(8'(UPD), "R5");

    // R9 out of range
    cycle(1'b1, 8'h70, 8'hAA);
    cycle(1'b1, 8'hFF, 8'h55);
    chk_rd(8'h70, "R9");
    chk_rd(8'hFF, "R9");
    for (int k = 0; k < NREG; k++) chk_rd(8'(k), "R9");

    // R11 back-to-back commits
    cycle(1'b1, 8'(UPD), 8'h01);
    cycle(1'b1, 8'(UPD), 8'h05);
    chk_rd(8'(UPD), "R11");
    chk_live("R11");
    cycle(1'b0, 8'h00, 8'h00);
    chk_live("R11");
    chk_rd(8'(UPD), "R5");

    // R2..R9 mixed random
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [7:0] d;
      logic       we;
      we = ($urandom_range(0, 3) != 0);
      a  = ($urandom_range(0, 7) == 0) ? 8'(UPD) : 8'($urandom_range(0, 127));
      d  = 8'($urandom);
      cycle(we, a, d);
      chk_live("R6");
      chk_mode("R8");
      chk_rd(8'($urandom_range(0, 255)), "R7");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule